// File: doc/BRIEF.md
# Bus Output-Enable Early Cutoff Controller

This block produces the active-low output enable for a bridge's data-bus drivers. The bridge answers a slow host bus while running on a fast logic clock. The host phase clock only reaches the logic domain after a synchronizer-and-debounce chain, and that chain adds a fixed delay of a few logic cycles. If the output enable followed the request alone, the bridge would keep driving the bus for that whole delay after the true phase edge. By then the host has already moved on to its next cycle.

The card read request goes straight to the enable through gates only, with no register in the path. A register would push the release one cycle later, into the next phase. A counter restarts on every edge of the delayed phase clock and advances once per logic clock. When the count reaches a cutoff, the enable is forced off.

The cutoff is set just past the estimated true phase edge. Its value is the nominal phase length in logic cycles, minus the synchronizer delay, plus a tunable margin. With the defaults (26, 6, 2) the forced release lands at count 22. This is well after the write-data capture window, which ends at count 13.

Top module: `bus_oe_cutoff`

## Requirements
- R1: Outside reset, `dataOeN` is 0 when `cardReadEn` and `busDataEn` are both 1 and the phase count is below the cutoff. It is 1 in every other case.
- R2: The path from `cardReadEn` to `dataOeN` has no register. A change of the request within a cycle shows on `dataOeN` in that same cycle, before the next clock edge.
- R3: A change of `phaseDly` (rising or falling), seen at a clock edge, sets the phase count to 0 for the following cycle. Each later clock edge without a change adds 1.
- R4: The cutoff is PHASE_COUNT − CDC_DELAY + OE_MARGIN, which is 22 with the defaults. While the count is at or above the cutoff, `dataOeN` is 1 whatever the request.
- R5: OE_MARGIN is a parameter in the range 1 to 4. With OE_MARGIN = 4 and the other defaults, the request is honoured through count 23 and released from count 24.
- R6: The phase count saturates at 2^CNT_W − 1 and never wraps. If no phase edge arrives, the enable stays released until the next edge.
- R7: While `rstN` is 0, `dataOeN` is 1 and `cutoffHit` is 0. The count and the stored phase level clear to 0 at each clock edge in that state.
- R8: Call a cycle an override cycle when the request and the global enable are both 1 and the count is at or above the cutoff. `cutoffHit` is 1 for exactly one cycle: the cycle after the first override cycle of a consecutive run. Otherwise it is 0.
- R9: A request is honoured across the write-capture window, counts 10 through 13. A parameter set whose cutoff is at or below WR_DONE_CNT (13) is rejected when the design is elaborated.
- R10: When `busDataEn` is 0, `dataOeN` stays 1 and `cutoffHit` stays 0, whatever the request and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Synchronous active-low reset |
| phaseDly | input | 1 | Host phase clock after the synchronizer delay, already in the logic domain |
| cardReadEn | input | 1 | Card request to drive read data onto the bus |
| busDataEn | input | 1 | Global permission for bus data output |
| dataOeN | output | 1 | Active-low data-bus output enable |
| cutoffHit | output | 1 | One-cycle pulse when the cutoff has overridden an asserted request |

## Verification
The bench builds two instances side by side from the same inputs. One has the default timing parameters and a 5-bit counter. The other is identical except for OE_MARGIN = 4, so a single stimulus stream shows release at count 22 and at count 24.

Shrinking the counter to 5 bits places saturation at count 31. A phase with its edge withheld for about a hundred cycles then reaches the point where a wrapping counter would re-enable the drivers. The default width only needs a longer wait for the same check.

// File: rtl/oe_cut_pkg.sv
package oe_cut_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clearCnt;  // a delayed phase edge was seen this cycle
    logic stepCnt;   // advance the count by one
  } cntStrobe_t;

endpackage

// File: rtl/oe_cut_dpath.sv
module oe_cut_dpath
  import oe_cut_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CUTOFF = 22
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] phaseCount,
  output logic             atCutoff,
  output logic             atMax
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CUT_VALUE = CNT_W'(CUTOFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCount <= '0;
    end else if (strobe.clearCnt) begin
      phaseCount <= '0;
    end else if (strobe.stepCnt) begin
      phaseCount <= phaseCount + 1'b1;
    end
  end

  assign atCutoff = (phaseCount >= CUT_VALUE);
  assign atMax    = (phaseCount == CNT_MAX);

  // R3: an edge strobe from control leaves a zero count behind it
  p_clear_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (phaseCount == '0));

  // R3: without an edge the count advances by exactly one below the ceiling
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearCnt && (phaseCount != CNT_MAX)) |=> (phaseCount == $past(phaseCount) + 1'b1));

  // R6: at the ceiling the count holds instead of wrapping
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearCnt && (phaseCount == CNT_MAX)) |=> (phaseCount == CNT_MAX));

endmodule

// File: rtl/oe_cut_ctrl.sv
module oe_cut_ctrl
  import oe_cut_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseDly,
  input  logic       cardReadEn,
  input  logic       busDataEn,
  input  logic       atCutoff,
  input  logic       atMax,
  output cntStrobe_t strobe,
  output logic       dataOeN,
  output logic       cutoffHit
);

  logic phasePrev;
  logic edgeSeen;
  logic driveWanted;
  logic overrideNow;
  logic overridePrev;

  // Edge detection on the already-synchronized phase
  always_ff @(posedge clk) begin
    if (!rstN) phasePrev <= 1'b0;
    else       phasePrev <= phaseDly;
  end

  assign edgeSeen        = phaseDly ^ phasePrev;
  assign strobe.clearCnt = edgeSeen;
  assign strobe.stepCnt  = !edgeSeen && !atMax;

  // Enable gating: gates only, so the release is never held back a cycle
  assign driveWanted = cardReadEn & busDataEn & rstN;
  assign dataOeN     = ~(driveWanted & ~atCutoff);
  assign overrideNow = driveWanted & atCutoff;

  // Debug pulse on the first override of a run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overridePrev <= 1'b0;
      cutoffHit    <= 1'b0;
    end else begin
      overridePrev <= overrideNow;
      cutoffHit    <= overrideNow & ~overridePrev;
    end
  end

  // R8: the pulse lasts a single cycle while an override run continues
  p_hit_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cutoffHit && $past(cutoffHit) == 1'b0 && overrideNow) |=> !cutoffHit);

  // R8: a pulse is caused by a request met at or past the cutoff
  p_hit_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cutoffHit) |-> $past(cardReadEn && busDataEn && atCutoff));

  // R10: with output globally disabled no pulse is produced
  p_no_hit_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busDataEn |=> !cutoffHit);

endmodule

// File: rtl/bus_oe_cutoff.sv
module bus_oe_cutoff
  import oe_cut_pkg::*;
#(
  parameter int PHASE_COUNT = 26,
  parameter int CDC_DELAY   = 6,
  parameter int OE_MARGIN   = 2,
  parameter int WR_DONE_CNT = 13,
  parameter int CNT_W       = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseDly,
  input  logic cardReadEn,
  input  logic busDataEn,
  output logic dataOeN,
  output logic cutoffHit
);

  localparam int EDGE_EST   = PHASE_COUNT - CDC_DELAY;
  localparam int CUTOFF_CNT = EDGE_EST + OE_MARGIN;
  localparam int CNT_CEIL   = (1 << CNT_W) - 1;

  // R9: elaboration-time parameter screening
  generate
    if (CUTOFF_CNT <= WR_DONE_CNT) begin : g_bad_cutoff
      $error("cutoff %0d does not clear write capture end %0d", CUTOFF_CNT, WR_DONE_CNT);
    end
    if (CUTOFF_CNT > CNT_CEIL) begin : g_bad_width
      $error("cutoff %0d exceeds counter ceiling %0d", CUTOFF_CNT, CNT_CEIL);
    end
    if (CDC_DELAY >= PHASE_COUNT) begin : g_bad_delay
      $error("delay %0d not below phase length %0d", CDC_DELAY, PHASE_COUNT);
    end
  endgenerate

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] phaseCount;
  logic             atCutoff;
  logic             atMax;

  oe_cut_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseDly   (phaseDly),
    .cardReadEn (cardReadEn),
    .busDataEn  (busDataEn),
    .atCutoff   (atCutoff),
    .atMax      (atMax),
    .strobe     (strobe),
    .dataOeN    (dataOeN),
    .cutoffHit  (cutoffHit)
  );

  oe_cut_dpath #(
    .CNT_W  (CNT_W),
    .CUTOFF (CUTOFF_CNT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phaseCount (phaseCount),
    .atCutoff   (atCutoff),
    .atMax      (atMax)
  );

  // R1: the drivers are only ever enabled below the cutoff count
  p_drive_below_cutoff_r1: assert property (@(posedge clk) disable iff (!rstN)
    !dataOeN |-> (int'(phaseCount) < CUTOFF_CNT));

  // R4: a held request is released on the cycle the count reaches the cutoff
  p_release_at_cutoff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(phaseCount) == CUTOFF_CNT - 1 && !strobe.clearCnt) |=> dataOeN);

  // R9: a drive requested inside the capture window is honoured
  p_capture_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cardReadEn && busDataEn && int'(phaseCount) <= WR_DONE_CNT) |-> !dataOeN);

endmodule

// File: tb/sim_bus_oe_cutoff.sv
module sim_bus_oe_cutoff;

  localparam int CNT_W = 5;
  localparam int CUT0  = 22;          // 26 - 6 + 2
  localparam int CUT1  = 24;          // 26 - 6 + 4
  localparam int MAXC  = 31;          // 2**5 - 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseDly = 1'b0;
  logic cardReadEn = 1'b0;
  logic busDataEn = 1'b0;
  logic oeN0, hit0, oeN1, hit1;

  always #10 clk = ~clk;  // 50 MHz

  bus_oe_cutoff #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .phaseDly(phaseDly), .cardReadEn(cardReadEn),
    .busDataEn(busDataEn), .dataOeN(oeN0), .cutoffHit(hit0)
  );

  bus_oe_cutoff #(.CNT_W(CNT_W), .OE_MARGIN(4)) u1 (
    .clk(clk), .rstN(rstN), .phaseDly(phaseDly), .cardReadEn(cardReadEn),
    .busDataEn(busDataEn), .dataOeN(oeN1), .cutoffHit(hit1)
  );

  typedef struct {
    logic  expOe0;
    logic  expOe1;
    logic  expHit;
    string tag0;
    string tag1;
  } item_t;

  item_t sbq[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // Reference state kept from the requirements
  int   mCnt = 0;
  logic mPrev = 1'b0;
  logic mOvPrev = 1'b0;
  logic mHit = 1'b0;
  logic curPh = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic string pickTag(input int cnt, input int cut, input logic rs, input logic en);
    if (!rs) return "R7";
    if (!en) return "R10";
    if (cnt == MAXC) return "R6";
    if (cnt >= 10 && cnt <= 13) return "R9";
    if (cnt >= cut) return "R4";
    if (cnt == 0) return "R3";
    return "R1";
  endfunction

  // Advance the reference state at a clock edge (R3, R6, R7, R8)
  task automatic modelStep(input logic ph, input logic rq, input logic en, input logic rs);
    logic ov;
    if (!rs) begin
      mCnt = 0; mPrev = 1'b0; mOvPrev = 1'b0; mHit = 1'b0;
    end else begin
      ov = rq && en && (mCnt >= CUT0);
      mHit = ov && !mOvPrev;
      mOvPrev = ov;
      if (ph != mPrev) mCnt = 0;
      else if (mCnt < MAXC) mCnt = mCnt + 1;
      mPrev = ph;
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic cyc(input logic ph, input logic rq, input logic en, input logic rs);
    item_t it;
    @(negedge clk);
    #1;
    phaseDly = ph; cardReadEn = rq; busDataEn = en; rstN = rs;
    it.expOe0 = !(rs && rq && en && (mCnt < CUT0));
    it.expOe1 = !(rs && rq && en && (mCnt < CUT1));
    it.expHit = mHit;
    it.tag0 = pickTag(mCnt, CUT0, rs, en);
    it.tag1 = (rs && en && mCnt >= 20 && mCnt < MAXC) ? "R5" : pickTag(mCnt, CUT1, rs, en);
    sbq.push_back(it);
    @(posedge clk);
    modelStep(ph, rq, en, rs);
  endtask

  // Monitor: pops expected items and compares with the design outputs
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(it.tag0, "oe u0", oeN0, it.expOe0);
        check(it.tag1, "oe u1", oeN1, it.expOe1);
        check("R8", "hit u0", hit0, it.expHit);
      end
    end
  end

  // One phase: toggle the delayed phase then run len cycles; mode picks the request pattern
  task automatic runPhase(input int len, input int mode, input logic en);
    logic rq;
    curPh = ~curPh;
    for (int k = 0; k < len; k++) begin
      case (mode)
        0: rq = 1'b1;
        1: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; rq = lfsr[0]; end
        default: rq = (k < 20) || (k > 25);
      endcase
      cyc(curPh, rq, en, 1'b1);
    end
  endtask

  // R2: request change inside one cycle shows on the enable before the next edge
  task automatic midCycle();
    @(negedge clk);
    #1;
    phaseDly = curPh; busDataEn = 1'b1; rstN = 1'b1; cardReadEn = 1'b1;
    #2;
    check("R2", "oe asserts in-cycle", oeN0, (mCnt < CUT0) ? 1'b0 : 1'b1);
    cardReadEn = 1'b0;
    #2;
    check("R2", "oe releases in-cycle", oeN0, 1'b1);
    @(posedge clk);
    modelStep(curPh, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    // R7: reset with a live request
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    // R1/R3/R4/R5/R8/R9: full phases with the request held
    for (int p = 0; p < 6; p++) runPhase(26, 0, 1'b1);
    // R10: global enable off
    for (int p = 0; p < 2; p++) runPhase(26, 0, 1'b0);
    // Mixed request patterns
    for (int p = 0; p < 4; p++) runPhase(26, 1, 1'b1);
    // R8: request absent across the cutoff, back afterwards
    runPhase(30, 2, 1'b1);
    // R6: edge withheld long past the counter ceiling
    runPhase(120, 0, 1'b1);
    runPhase(26, 0, 1'b1);
    // R2: in-cycle behaviour just after an edge
    curPh = ~curPh;
    cyc(curPh, 1'b0, 1'b1, 1'b1);
    midCycle();
    midCycle();
    for (int k = 0; k < 24; k++) cyc(curPh, 1'b1, 1'b1, 1'b1);
    // R7: reset in the middle of a drive, then recovery
    for (int i = 0; i < 3; i++) cyc(curPh, 1'b1, 1'b1, 1'b0);
    curPh = 1'b0;
    runPhase(26, 0, 1'b1);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  // Watchdog
  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule